// File: doc/BRIEF.md
# Multithreaded Fetch Thread Picker

Each cycle this block decides which hardware thread the instruction fetch stage serves. It reads a status code for every thread, the per-thread instruction-queue and load/store-queue occupancy counts, the number of configured threads and a policy select. It returns a thread ID with a valid flag, or raises a "none" flag when no thread can be served. When the fetch stage sees "none" it gives up on further threads for that cycle.

Four policies are supported: a single-thread mode, a rotating mode that walks an ordered priority list, and two occupancy modes that favour the thread with the emptiest instruction queue or the emptiest load/store queue. The selection is purely combinational from the inputs. The only state is the rotating priority list. It changes at a clock edge only when the fetch stage accepts a grant in rotating mode.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its 3-bit status is 0 (running), 1 (cache fill returned) or 2 (idle) and its index is at most `thr_cnt_m1`. Status codes 3 to 7 make it ineligible.
- R2: Exactly one of `sel_valid` and `sel_none` is high in every cycle. `sel_tid` reads 0 whenever `sel_none` is high, and a granted thread is always eligible.
- R3: With one thread configured (`thr_cnt_m1` = 0), the block grants thread 0 if it is eligible and reports none otherwise, under every policy.
- R4: Policy code 0 (single) selects thread 0. With more than one thread configured, policy 0 raises `cfg_bad` and reports none.
- R5: Policy code 1 (rotate) scans the priority list from the head and grants the first eligible thread in it.
- R6: When a rotate-mode grant is accepted with more than one thread configured, the granted thread moves to the tail of the list. The other entries keep their relative order.
- R7: After reset the priority list holds thread IDs in ascending order, with thread 0 at the head.
- R8: The priority list does not change when `grant_accept` is low, when the policy is not rotate, when there is no grant, or when only one thread is configured.
- R9: Policy code 2 grants the eligible thread with the lowest instruction-queue count. Ties go to the lower thread ID.
- R10: Policy code 3 grants the eligible thread with the lowest load/store-queue count. Ties go to the lower thread ID.
- R11: The outputs follow input changes within the same cycle, with no register between the inputs and `sel_*`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_status | input | 12 | 3-bit status per thread, thread i at bits [3i+2:3i] |
| iq_cnt | input | 24 | 6-bit instruction-queue occupancy per thread |
| lsq_cnt | input | 24 | 6-bit load/store-queue occupancy per thread |
| thr_cnt_m1 | input | 2 | Number of configured threads minus one |
| policy | input | 2 | 0 single, 1 rotate, 2 IQ count, 3 LSQ count |
| grant_accept | input | 1 | Fetch stage takes this cycle's grant |
| sel_valid | output | 1 | A thread is granted |
| sel_none | output | 1 | No thread can be served this cycle |
| sel_tid | output | 2 | Granted thread ID |
| cfg_bad | output | 1 | Single policy used with more than one thread |

## Verification
The hardest state to reach is a priority list that has been rotated into an uneven order, with some entries skipped over because they were ineligible. That order is invisible at the ports until a later scan runs into it. The bench reaches it with accepted rotate-mode grants while selected threads are blocked, so that non-head entries get granted and moved. It then makes all threads eligible again and reads the resulting order back, one accepted grant at a time. A reference list in the bench follows the same sequence. The hold rule is reached the same way: grants are offered but not accepted, then the policy is switched away and back, and the head read afterwards must be unchanged.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RUN        = 3'd0,
    ST_FILL_DONE  = 3'd1,
    ST_IDLE       = 3'd2,
    ST_BLOCKED    = 3'd3,
    ST_SQUASH     = 3'd4,
    ST_MISS_WAIT  = 3'd5,
    ST_RETRY_WAIT = 3'd6,
    ST_PARKED     = 3'd7
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_SOLO   = 2'd0,
    POL_ROTATE = 2'd1,
    POL_IQ     = 2'd2,
    POL_LSQ    = 2'd3
  } pol_e;

  // True when a thread in this state may receive fetch bandwidth.
  function automatic logic state_can_fetch(input logic [ST_W-1:0] s);
    case (s)
      ST_RUN, ST_FILL_DONE, ST_IDLE: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic [NTHR*fts_pkg::ST_W-1:0] status,
  input  logic [TID_W-1:0]              cnt_m1,
  output logic [NTHR-1:0]               elig
);
  import fts_pkg::*;

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    logic in_range;
    assign in_range = (TID_W'(i) <= cnt_m1);
    assign elig[i]  = in_range && state_can_fetch(status[i*ST_W +: ST_W]);
  end
endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTHR-1:0]         elig,
  input  logic                    adv,
  output logic                    hit,
  output logic [TID_W-1:0]        tid,
  output logic [NTHR*TID_W-1:0]   order_flat
);
  logic [TID_W-1:0] order_q [NTHR];
  logic [TID_W-1:0] pos;

  // Scan from the tail down so the entry nearest the head wins.
  always_comb begin
    hit = 1'b0;
    pos = '0;
    tid = '0;
    for (int p = NTHR - 1; p >= 0; p--) begin
      if (elig[order_q[p]]) begin
        hit = 1'b1;
        pos = TID_W'(p);
        tid = order_q[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NTHR; p++) order_q[p] <= TID_W'(p);
    end else if (adv && hit) begin
      for (int p = 0; p < NTHR - 1; p++) begin
        if (TID_W'(p) >= pos) order_q[p] <= order_q[p+1];
      end
      order_q[NTHR-1] <= tid;
    end
  end

  for (genvar p = 0; p < NTHR; p++) begin : g_flat
    assign order_flat[p*TID_W +: TID_W] = order_q[p];
  end
endmodule

// File: rtl/fts_min_rank.sv
module fts_min_rank #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2,
  parameter int CNT_W = 6
) (
  input  logic [NTHR-1:0]       elig,
  input  logic [NTHR*CNT_W-1:0] cnt,
  output logic                  hit,
  output logic [TID_W-1:0]      tid
);
  logic [CNT_W-1:0] best;

  // Ascending scan with strict less-than keeps the lower ID on ties.
  always_comb begin
    hit  = 1'b0;
    tid  = '0;
    best = '0;
    for (int i = 0; i < NTHR; i++) begin
      if (elig[i] && (!hit || cnt[i*CNT_W +: CNT_W] < best)) begin
        hit  = 1'b1;
        tid  = TID_W'(i);
        best = cnt[i*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR  = 4,
  parameter int CNT_W = 6,
  localparam int TID_W = $clog2(NTHR),
  localparam int ST_W  = fts_pkg::ST_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTHR*ST_W-1:0]    thr_status,
  input  logic [NTHR*CNT_W-1:0]   iq_cnt,
  input  logic [NTHR*CNT_W-1:0]   lsq_cnt,
  input  logic [TID_W-1:0]        thr_cnt_m1,
  input  logic [1:0]              policy,
  input  logic                    grant_accept,
  output logic                    sel_valid,
  output logic                    sel_none,
  output logic [TID_W-1:0]        sel_tid,
  output logic                    cfg_bad
);
  import fts_pkg::*;

  logic [NTHR-1:0]       elig;
  logic                  one_thr;
  logic                  rr_hit, rank_hit, pick_hit;
  logic [TID_W-1:0]      rr_tid, rank_tid, pick_tid;
  logic                  rr_adv;
  logic [NTHR*TID_W-1:0] order_flat;
  logic [NTHR*CNT_W-1:0] rank_cnt;

  fts_elig #(.NTHR(NTHR), .TID_W(TID_W)) elig_i (
    .status(thr_status), .cnt_m1(thr_cnt_m1), .elig(elig)
  );

  assign one_thr  = (thr_cnt_m1 == '0);
  assign rr_adv   = grant_accept && (pol_e'(policy) == POL_ROTATE) && !one_thr;
  assign rank_cnt = (pol_e'(policy) == POL_LSQ) ? lsq_cnt : iq_cnt;

  fts_rr_list #(.NTHR(NTHR), .TID_W(TID_W)) rr_i (
    .clk(clk), .rst_n(rst_n), .elig(elig), .adv(rr_adv),
    .hit(rr_hit), .tid(rr_tid), .order_flat(order_flat)
  );

  fts_min_rank #(.NTHR(NTHR), .TID_W(TID_W), .CNT_W(CNT_W)) rank_i (
    .elig(elig), .cnt(rank_cnt), .hit(rank_hit), .tid(rank_tid)
  );

  always_comb begin
    pick_hit = 1'b0;
    pick_tid = '0;
    if (one_thr) begin
      pick_hit = elig[0];
    end else begin
      case (pol_e'(policy))
        POL_SOLO:   pick_hit = 1'b0;
        POL_ROTATE: begin pick_hit = rr_hit;   pick_tid = rr_tid;   end
        default:    begin pick_hit = rank_hit; pick_tid = rank_tid; end
      endcase
    end
  end

  assign sel_valid = pick_hit;
  assign sel_none  = !pick_hit;
  assign sel_tid   = pick_hit ? pick_tid : '0;
  assign cfg_bad   = (pol_e'(policy) == POL_SOLO) && !one_thr;
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NTHR-1:0]       elig,
  input logic                  sel_valid,
  input logic                  sel_none,
  input logic [TID_W-1:0]      sel_tid,
  input logic [TID_W-1:0]      thr_cnt_m1,
  input logic                  cfg_bad,
  input logic                  rr_adv,
  input logic [NTHR*TID_W-1:0] order_flat
);
  p_valid_xor_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid != sel_none);

  p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig[sel_tid]);

  p_solo_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> sel_none);

  p_one_thread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_cnt_m1 == '0) |-> (sel_valid == elig[0] && sel_tid == '0));

  p_tail_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_adv && sel_valid) |=>
      order_flat[(NTHR-1)*TID_W +: TID_W] == $past(sel_tid));

  p_list_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rr_adv && sel_valid) |=> $stable(order_flat));
endmodule

bind fetch_thread_sel fts_checker #(.NTHR(NTHR), .TID_W(TID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .elig(elig), .sel_valid(sel_valid),
  .sel_none(sel_none), .sel_tid(sel_tid), .thr_cnt_m1(thr_cnt_m1),
  .cfg_bad(cfg_bad), .rr_adv(rr_adv), .order_flat(order_flat)
);

// File: tb/fetch_thread_sel_tb_top.sv
module fetch_thread_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 4;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]       st  [NTHR];
  logic [CNT_W-1:0] iq  [NTHR];
  logic [CNT_W-1:0] lsq [NTHR];
  logic [1:0] cntm1 = 2'd3;
  logic [1:0] pol = 2'd1;
  logic accept = 1'b0;
  logic [NTHR*3-1:0] st_flat;
  logic [NTHR*CNT_W-1:0] iq_flat, lsq_flat;
  logic sel_valid, sel_none, cfg_bad;
  logic [1:0] sel_tid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] mlist [NTHR];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < NTHR; i++) begin : g_pack
    assign st_flat[i*3 +: 3]      = st[i];
    assign iq_flat[i*CNT_W +: CNT_W]  = iq[i];
    assign lsq_flat[i*CNT_W +: CNT_W] = lsq[i];
  end

  fetch_thread_sel #(.NTHR(NTHR), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_status(st_flat), .iq_cnt(iq_flat),
    .lsq_cnt(lsq_flat), .thr_cnt_m1(cntm1), .policy(pol),
    .grant_accept(accept), .sel_valid(sel_valid), .sel_none(sel_none),
    .sel_tid(sel_tid), .cfg_bad(cfg_bad)
  );

  // Reference pick, written from the requirements.
  task automatic model(output logic h, output logic [1:0] t);
    logic e [NTHR];
    logic [CNT_W-1:0] c, best;
    for (int i = 0; i < NTHR; i++) e[i] = (st[i] <= 3'd2) && (i <= int'(cntm1));
    h = 0; t = 0; best = 0;
    if (cntm1 == 0) h = e[0];
    else if (pol == 2'd1) begin
      for (int p = 0; p < NTHR; p++)
        if (!h && e[mlist[p]]) begin h = 1; t = mlist[p]; end
    end else if (pol != 2'd0) begin
      for (int i = 0; i < NTHR; i++) begin
        c = (pol == 2'd2) ? iq[i] : lsq[i];
        if (e[i] && (!h || c < best)) begin h = 1; t = 2'(i); best = c; end
      end
    end
  endtask

  task automatic step(input string rq, input bit clk_after);
    logic eh; logic [1:0] et; logic eb; int pos;
    #1;
    model(eh, et);
    eb = (pol == 2'd0) && (cntm1 != 0);
    checks++;
    if (sel_valid !== eh || sel_none !== !eh || sel_tid !== (eh ? et : 2'd0) || cfg_bad !== eb) begin
      errors++;
      $display("FAIL %s: valid=%0b tid=%0d bad=%0b expected valid=%0b tid=%0d bad=%0b",
               rq, sel_valid, sel_tid, cfg_bad, eh, eh ? et : 2'd0, eb);
    end
    if (clk_after) begin
      @(posedge clk);
      if (accept && pol == 2'd1 && cntm1 != 0 && eh) begin
        pos = 0;
        for (int p = 0; p < NTHR; p++) if (mlist[p] == et) pos = p;
        for (int p = 0; p < NTHR - 1; p++) if (p >= pos) mlist[p] = mlist[p+1];
        mlist[NTHR-1] = et;
      end
      @(negedge clk);
    end
  endtask

  task automatic set_all(input logic [2:0] s);
    for (int i = 0; i < NTHR; i++) st[i] = s;
  endtask

  task automatic t_reset;
    cntm1 = 3; pol = 1; accept = 0;
    set_all(3'd3);
    step("R2 reset none", 1);
    set_all(3'd0);
    step("R7 reset head", 1);
  endtask

  task automatic t_elig;
    cntm1 = 3; pol = 1; accept = 0;
    for (int c = 0; c < 8; c++) begin
      set_all(3'd3); st[2] = 3'(c);
      step("R1 status code", 1);
    end
    cntm1 = 1; set_all(3'd3); st[3] = 3'd0;
    step("R1 beyond count", 1);
    st[1] = 3'd1;
    step("R1 within count", 1);
  endtask

  task automatic t_one_thread;
    cntm1 = 0; accept = 1;
    for (int p = 0; p < 4; p++) begin
      pol = 2'(p);
      set_all(3'd0);
      step("R3 one thread ok", 1);
      st[0] = 3'd5;
      step("R3 one thread none", 1);
    end
  endtask

  task automatic t_solo;
    cntm1 = 3; pol = 0; accept = 1; set_all(3'd0);
    step("R4 solo illegal", 1);
    cntm1 = 2;
    step("R4 solo illegal 3thr", 1);
  endtask

  task automatic t_rr;
    cntm1 = 3; pol = 1; accept = 1; set_all(3'd0);
    for (int k = 0; k < 6; k++) step("R5 R6 rotate all", 1);
    st[2] = 3'd3; st[3] = 3'd4;
    for (int k = 0; k < 3; k++) step("R5 rotate skip", 1);
    set_all(3'd0);
    for (int k = 0; k < 4; k++) step("R6 order readback", 1);
  endtask

  task automatic t_hold;
    cntm1 = 3; pol = 1; accept = 0; set_all(3'd0);
    for (int k = 0; k < 3; k++) step("R8 no accept", 1);
    pol = 2; accept = 1;
    for (int k = 0; k < 2; k++) step("R8 other policy", 1);
    pol = 1; accept = 0;
    step("R8 head kept", 1);
    set_all(3'd3); accept = 1;
    step("R8 no grant", 1);
    set_all(3'd0); accept = 0;
    step("R8 head after none", 1);
  endtask

  task automatic t_iq;
    cntm1 = 3; pol = 2; accept = 1; set_all(3'd0);
    iq[0] = 5; iq[1] = 3; iq[2] = 3; iq[3] = 9;
    lsq[0] = 0; lsq[1] = 40; lsq[2] = 40; lsq[3] = 40;
    step("R9 iq tie low id", 1);
    st[1] = 3'd6;
    step("R9 iq skip blocked", 1);
    iq[3] = 0;
    step("R9 iq min", 1);
  endtask

  task automatic t_lsq;
    cntm1 = 3; pol = 3; accept = 1; set_all(3'd0);
    lsq[0] = 2; lsq[1] = 7; lsq[2] = 2; lsq[3] = 0;
    iq[0] = 63; iq[1] = 0; iq[2] = 0; iq[3] = 0;
    step("R10 lsq min", 1);
    st[3] = 3'd3;
    step("R10 lsq tie", 1);
    cntm1 = 1; lsq[1] = 1;
    step("R10 lsq count limit", 1);
  endtask

  task automatic t_comb;
    cntm1 = 3; pol = 2; accept = 0; set_all(3'd0);
    iq[0] = 1; iq[1] = 2; iq[2] = 3; iq[3] = 4;
    step("R11 before change", 0);
    st[0] = 3'd3;
    step("R11 same cycle", 0);
    iq[3] = 0;
    step("R11 count change", 1);
  endtask

  initial begin
    for (int i = 0; i < NTHR; i++) begin
      st[i] = 3'd0; iq[i] = '0; lsq[i] = '0; mlist[i] = 2'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_elig;
    t_one_thread;
    t_solo;
    t_rr;
    t_hold;
    t_iq;
    t_lsq;
    t_comb;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule